// File: doc/BRIEF.md
# Per-Operand Element Remap Selector

This block sequences the element loop of one vector operation. For every element it gives each of five operand slots an element offset. The slots are three sources and two destinations. The second destination carries the effective address, or the base register that a load/store-with-update writes back.

A control word binds each slot to one of four shared shape generators. The generators are external, and the current index of each one arrives on an input. For each slot, the control word either forwards the index of the chosen generator or leaves the slot on its own linear counter. A linear counter moves forward only when its operand is a vector.

The block also tells the issue stage whether each element is enabled by its predicate bit. It cuts the loop short after the first element when the primary destination is scalar. When two operands are remapped at once, as twin-predicated operations require, each gets its own independently selected offset.

Top module: `remap_select_unit`

## Requirements
- R1: When `cfgWrEn` is high at a rising edge, bits 14:0 of `cfgWrData` are stored. From the next cycle they appear on `cfgRdData[14:0]`. After reset the stored value is zero.
- R2: `cfgRdData[23:15]` always reads zero, whatever value was written.
- R3: Operand slots are numbered 0..4: source A, source B, source C, primary destination, second destination. When enable bit `cfg[10+k]` is clear, slot k's offset is that slot's own linear counter.
- R4: When `cfg[10+k]` is set, slot k's offset equals the index of the generator selected by `cfg[2k+1:2k]`. Generator g's index is `shapeIdx[g*IDX_W +: IDX_W]`, and the offset follows it in the same cycle.
- R5: A `start` accepted while idle runs elements 0, 1, 2 … one per cycle, beginning the cycle after the start. `stepValid` stays high through the run, `stepIdx` carries the element number, and `stepLast` marks the final element. `stepValid` drops the cycle after that.
- R6: `stepIssue` is high exactly when `stepValid` is high and the latched predicate bit numbered `stepIdx` is set.
- R7: When the latched flag `opIsVec[3]` (primary destination) is 0, the run has exactly one element, and that element carries `stepLast`.
- R8: Every linear counter is zero at the first element. After each element it increments only if its operand's latched vector flag is set, whether or not the element was issued. A scalar operand's counter stays at zero.
- R9: `start` is ignored while a run is in progress, and also when `vecLen` is zero.
- R10: A `vecLen` above `MAX_VL` runs `MAX_VL` elements.
- R11: `predMask`, `opIsVec` and `vecLen` are sampled when the run starts. Later changes to them do not affect that run.
- R12: Several slots may select the same generator or different generators. Each enabled slot follows its own selection independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 24 | Control word write value |
| cfgRdData | output | 24 | Control word read value |
| start | input | 1 | Launch an element loop |
| vecLen | input | CNT_W (7) | Element count for the run |
| predMask | input | MAX_VL (64) | Per-element predicate bits |
| opIsVec | input | 5 | Vector flag per operand slot |
| shapeIdx | input | 4*IDX_W (28) | Current index of each of the four shape generators |
| stepValid | output | 1 | An element is in progress this cycle |
| stepIssue | output | 1 | This element is enabled by its predicate |
| stepLast | output | 1 | This element is the final one |
| stepIdx | output | CNT_W (7) | Element number |
| opOffset | output | 5*IDX_W (35) | Element offset per slot, slot k at bits k*IDX_W |

## Verification
The hardest case to reach from the ports is proving that sampling really happened at launch. The stimulus for this flips `predMask` and `opIsVec` on the first element of every run. It also pulses `start` again in the middle of longer runs. Any live use of these inputs, or any restart, would then show up as wrong issue bits, wrong offsets or a reset element number.

Generator indices change on every element, so a stale selection is not masked by a constant value. A run with `vecLen` above the maximum covers the clamp, and it alternates predicate bits across all 64 elements.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int NUM_OPS    = 5;
  localparam int NUM_SHAPES = 4;
  localparam int SEL_W      = $clog2(NUM_SHAPES);
  localparam int ENA_LSB    = NUM_OPS * SEL_W;
  localparam int CFG_USED   = ENA_LSB + NUM_OPS;
  localparam int CFG_W      = 24;

  // Strobes from sequencing control to the offset datapath.
  typedef struct packed {
    logic                clearCnt;
    logic                advance;
    logic [NUM_OPS-1:0]  vecMask;
  } seq_strobe_t;
endpackage

// File: rtl/remap_seq_ctrl.sv
module remap_seq_ctrl
  import remap_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int CNT_W  = $clog2(MAX_VL + 1),
  localparam int PIDX_W = $clog2(MAX_VL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   vecLen,
  input  logic [MAX_VL-1:0]  predMask,
  input  logic [NUM_OPS-1:0] opIsVec,
  output seq_strobe_t        stb,
  output logic               stepValid,
  output logic               stepIssue,
  output logic               stepLast,
  output logic [CNT_W-1:0]   stepIdx
);
  localparam int DST_SLOT = 3;

  logic               running;
  logic [CNT_W-1:0]   elemCnt;
  logic [CNT_W-1:0]   vlReg;
  logic [MAX_VL-1:0]  predReg;
  logic [NUM_OPS-1:0] vecReg;
  logic               launch;
  logic               lastNow;
  logic [CNT_W-1:0]   vlClamped;

  assign launch    = !running && start && (vecLen != '0);
  assign vlClamped = (vecLen > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vecLen;
  assign lastNow   = running && ((elemCnt == vlReg - CNT_W'(1)) || !vecReg[DST_SLOT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      elemCnt <= '0;
      vlReg   <= '0;
      predReg <= '0;
      vecReg  <= '0;
    end else if (launch) begin
      running <= 1'b1;
      elemCnt <= '0;
      vlReg   <= vlClamped;
      predReg <= predMask;
      vecReg  <= opIsVec;
    end else if (running) begin
      if (lastNow) running <= 1'b0;
      else         elemCnt <= elemCnt + CNT_W'(1);
    end
  end

  always_comb begin
    stb.clearCnt = launch;
    stb.advance  = running;
    stb.vecMask  = vecReg;
  end

  assign stepValid = running;
  assign stepIssue = running && predReg[elemCnt[PIDX_W-1:0]];
  assign stepLast  = lastNow;
  assign stepIdx   = elemCnt;
endmodule

// File: rtl/remap_offset_path.sv
module remap_offset_path
  import remap_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [CFG_W-1:0]            cfgWrData,
  input  seq_strobe_t                 stb,
  input  logic [NUM_SHAPES*IDX_W-1:0] shapeIdx,
  output logic [CFG_W-1:0]            cfgRdData,
  output logic [NUM_OPS*IDX_W-1:0]    opOffset
);
  logic [CFG_USED-1:0] ctlReg;
  logic [IDX_W-1:0]    shapeArr [NUM_SHAPES];
  logic                unusedRsvBits;

  assign unusedRsvBits = ^cfgWrData[CFG_W-1:CFG_USED];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctlReg <= '0;
    else if (cfgWrEn) ctlReg <= cfgWrData[CFG_USED-1:0];
  end

  assign cfgRdData = {{(CFG_W-CFG_USED){1'b0}}, ctlReg};

  for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape
    assign shapeArr[g] = shapeIdx[g*IDX_W +: IDX_W];
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    logic [IDX_W-1:0] seqCnt;
    logic [SEL_W-1:0] selK;
    logic             enK;

    assign selK = ctlReg[k*SEL_W +: SEL_W];
    assign enK  = ctlReg[ENA_LSB + k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             seqCnt <= '0;
      else if (stb.clearCnt)                 seqCnt <= '0;
      else if (stb.advance && stb.vecMask[k]) seqCnt <= seqCnt + IDX_W'(1);
    end

    assign opOffset[k*IDX_W +: IDX_W] = enK ? shapeArr[selK] : seqCnt;
  end
endmodule

// File: rtl/remap_select_unit.sv
module remap_select_unit
  import remap_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 7,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [23:0]                 cfgWrData,
  output logic [23:0]                 cfgRdData,
  input  logic                        start,
  input  logic [CNT_W-1:0]            vecLen,
  input  logic [MAX_VL-1:0]           predMask,
  input  logic [4:0]                  opIsVec,
  input  logic [4*IDX_W-1:0]          shapeIdx,
  output logic                        stepValid,
  output logic                        stepIssue,
  output logic                        stepLast,
  output logic [CNT_W-1:0]            stepIdx,
  output logic [5*IDX_W-1:0]          opOffset
);
  seq_strobe_t stb;

  remap_seq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .predMask(predMask), .opIsVec(opIsVec), .stb(stb),
    .stepValid(stepValid), .stepIssue(stepIssue),
    .stepLast(stepLast), .stepIdx(stepIdx)
  );

  remap_offset_path #(.IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .stb(stb), .shapeIdx(shapeIdx), .cfgRdData(cfgRdData),
    .opOffset(opOffset)
  );
endmodule

// File: rtl/remap_select_unit_chk.sv
module remap_select_unit_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [23:0]      cfgWrData,
  input logic [23:0]      cfgRdData,
  input logic             stepValid,
  input logic             stepIssue,
  input logic             stepLast,
  input logic [CNT_W-1:0] stepIdx
);
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == ($past(cfgWrData) & 24'h007FFF)); // R1

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[23:15] == 9'd0); // R2

  AST_ISSUE_IN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stepIssue |-> stepValid); // R6

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !stepLast) |=> (stepValid && stepIdx == $past(stepIdx) + CNT_W'(1))); // R5

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepLast) |=> !stepValid); // R5

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepValid) |-> stepIdx == '0); // R5
endmodule

bind remap_select_unit remap_select_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .stepValid(stepValid), .stepIssue(stepIssue),
  .stepLast(stepLast), .stepIdx(stepIdx)
);

// File: tb/remap_select_unit_bench.sv
module remap_select_unit_bench;
  localparam int MAX_VL = 64;
  localparam int IDX_W  = 7;
  localparam int CNT_W  = $clog2(MAX_VL + 1);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 cfgWrEn = 1'b0;
  logic [23:0]          cfgWrData = '0;
  logic [23:0]          cfgRdData;
  logic                 start = 1'b0;
  logic [CNT_W-1:0]     vecLen = '0;
  logic [MAX_VL-1:0]    predMask = '0;
  logic [4:0]           opIsVec = '0;
  logic [4*IDX_W-1:0]   shapeIdx = '0;
  logic                 stepValid, stepIssue, stepLast;
  logic [CNT_W-1:0]     stepIdx;
  logic [5*IDX_W-1:0]   opOffset;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;
  logic [23:0] curCfg = '0;

  always #5 clk = ~clk;

  remap_select_unit #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_remap_select_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .start(start), .vecLen(vecLen),
    .predMask(predMask), .opIsVec(opIsVec), .shapeIdx(shapeIdx),
    .stepValid(stepValid), .stepIssue(stepIssue), .stepLast(stepLast),
    .stepIdx(stepIdx), .opOffset(opOffset)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] genIdx(input int g, input int n);
    return IDX_W'((g * 37 + n * 5 + 3) % 128);
  endfunction

  task automatic writeCfg(input logic [23:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
    #1;
    check(cfgRdData[14:0] == val[14:0], "R1 readback", cfgRdData[14:0], val[14:0]);
    check(cfgRdData[23:15] == 9'd0, "R2 reserved", cfgRdData[23:15], 0);
    curCfg = val & 24'h007FFF;
  endtask

  // Launch and check every element; flips live inputs after launch (R11)
  // and re-pulses start mid-run (R9).
  task automatic runLoop(input int vl, input logic [MAX_VL-1:0] pred,
                         input logic [4:0] isVec, input int expSteps, input string runTag);
    @(negedge clk);
    start = 1'b1; vecLen = CNT_W'(vl); predMask = pred; opIsVec = isVec;
    for (int n = 0; n < expSteps; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start = 1'b0; predMask = ~pred; opIsVec = ~isVec; vecLen = CNT_W'(2);
      end
      if (n == 1 && expSteps >= 3) begin start = 1'b1; vecLen = CNT_W'(5); end
      if (n == 2) start = 1'b0;
      for (int g = 0; g < 4; g++) shapeIdx[g*IDX_W +: IDX_W] = genIdx(g, n);
      #1;
      check(stepValid == 1'b1, {runTag, " R5 valid"}, stepValid, 1);
      check(stepIdx == CNT_W'(n), {runTag, " R5 index"}, stepIdx, n);
      check(stepLast == (n == expSteps - 1), {runTag, " R5 last"}, stepLast, (n == expSteps - 1));
      check(stepIssue == pred[n], {runTag, " R6/R11 issue"}, stepIssue, pred[n]);
      for (int k = 0; k < 5; k++) begin
        logic [IDX_W-1:0] exp;
        logic [IDX_W-1:0] act;
        bit en;
        en  = curCfg[10 + k];
        exp = en ? genIdx(int'(curCfg[2*k +: 2]), n) : (isVec[k] ? IDX_W'(n) : IDX_W'(0));
        act = opOffset[k*IDX_W +: IDX_W];
        check(act == exp, {runTag, en ? " R4 offset" : (isVec[k] ? " R3 offset" : " R8 offset")}, act, exp);
      end
    end
    @(negedge clk);
    #1;
    check(stepValid == 1'b0, {runTag, " R5 end"}, stepValid, 0);
  endtask

  task automatic testReset();
    #1;
    check(stepValid == 1'b0, "R5 reset idle", stepValid, 0);
    check(cfgRdData == 24'd0, "R1 reset cfg", cfgRdData, 0);
  endtask

  task automatic testCfg();
    writeCfg(24'hFFFFFF);
    writeCfg(24'hABCDEF);
  endtask

  task automatic testLinear();
    writeCfg(24'd0);
    runLoop(6, '1, 5'b11111, 6, "linear R3");
  endtask

  task automatic testMixed();
    // R8: slots 1 and 4 scalar, masked elements still advance counters
    runLoop(5, 64'b10110, 5'b01101, 5, "mixed R8");
  endtask

  task automatic testRemap();
    // R12: slots 0 and 2 share generator 2, slot 1 linear
    writeCfg(24'd30178);
    runLoop(7, 64'h55, 5'b11111, 7, "remap R12");
  endtask

  task automatic testScalarDst();
    writeCfg(24'd0);
    runLoop(8, '1, 5'b10111, 1, "scalar R7");
  endtask

  task automatic testClamp();
    writeCfg(24'h00FC00 | 24'd228);
    runLoop(100, {32{2'b01}}, 5'b11111, 64, "clamp R10");
  endtask

  task automatic testZeroLen();
    @(negedge clk);
    start = 1'b1; vecLen = '0;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(stepValid == 1'b0, "R9 zero length", stepValid, 0);
    @(negedge clk);
    #1;
    check(stepValid == 1'b0, "R9 zero length later", stepValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testCfg();
    testLinear();
    testMixed();
    testRemap();
    testScalarDst();
    testClamp();
    testZeroLen();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule